// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

An eight-pin general-purpose I/O port controller. A small register file, reached over a synchronous single-cycle bus, holds the direction, output data, edge polarity, interrupt flag and interrupt enable bits for every pin. From these bits the block produces three control vectors toward the pad ring: output enable, output value and weak pull-up enable. A pin used as an input with its output-data bit set has its pull-up turned on. The two top pins have no pull-up.

Pin levels enter through a two-flop synchronizer. The synchronized levels can always be read back, including when a pin is serving another function. A one-clock history of the synchronized level gives rising and falling edges. The edge chosen for each pin sets a sticky flag. Software can clear a flag or set it by hand. A single interrupt request is raised while any flag with its enable bit set stays set.

Bus writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and reads as 0 when it is low. Register addresses are: 0 direction, 1 output data, 2 pin level (read only), 3 edge select, 4 flags, 5 interrupt enables. Addresses 6 and 7 are unused.

Top module: `gpio_edge_port`

## Requirements
- R1: `pad_oe[n]` equals direction bit n (address 0). A 1 makes the pin an output and a 0 makes it an input. The register reads back as written.
- R2: `pad_out[n]` equals output-data bit n (address 1) while pin n is an output, and is 0 while it is an input. The register reads back as written.
- R3: For pins 0 to 5, `pad_pull_en[n]` is 1 exactly when pin n is an input and its output-data bit is 1. It is never 1 for an output pin.
- R4: `pad_pull_en[6]` and `pad_pull_en[7]` are 0 under every register setting.
- R5: Address 2 reads the pin levels through two flops. A level change applied before clock edge k is visible after edge k+1, whatever the direction setting. Writes to address 2 have no effect.
- R6: Edge select bit n (address 3) picks the edge for pin n: 0 means rising and 1 means falling. A selected edge applied before clock edge k sets flag n at edge k+2. The opposite edge sets nothing.
- R7: Flags (address 4) are sticky. A set flag stays 1 until a bus write to address 4 loads a 0 into it, or until reset.
- R8: A bus write to address 4 loads the written value into the flags. Writing a 1 sets a flag even when no edge has occurred.
- R9: `irq` is 1 exactly while some flag n and enable bit n (address 5) are both 1. Flags are set whether or not their enable bit is 1.
- R10: When a hardware edge and a bus write of 0 hit the same flag on the same clock edge, the flag ends up 1.
- R11: After reset every register reads 0, all three pad vectors and `irq` are 0, and a pin held high through reset sets no flag when reset is released.
- R12: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pull_en | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench puts a hardware edge and a bus clear on the same flag in the same cycle. A design that lets the write win loses that event, and the flag reads 0. It holds all pins high through reset and checks that no rising-edge flag shows up once the synchronizer fills. A design without a warm-up period flags every pin that is high at reset. It checks the pull-up enables on pins 6 and 7 with output data all ones, and checks opposite-edge polarity on a mixed edge-select setting. Random register writes, including writes to the unused addresses, are mixed with random pin changes so that stray writes and flags lost or set one cycle off show up in the register readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 3'd0,
        RA_DOUT  = 3'd1,
        RA_LEVEL = 3'd2,
        RA_EDGE  = 3'd3,
        RA_FLAG  = 3'd4,
        RA_IEN   = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Synchronizer chain plus one-cycle history; edges are masked until the
// chain has been refilled after reset.
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
        logic [STAGES:0]          fill;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     armed;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
        st_d.fill = {st_q.fill[STAGES-1:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed   = st_q.fill[STAGES];
    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = armed ? (level_o & ~st_q.prev) : '0;
    assign fall_o  = armed ? (~level_o & st_q.prev) : '0;

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Pad control decode; pins outside PULL_MASK get a pull-up tied off.
module gpio_pad_ctrl #(
    parameter int unsigned   W         = 8,
    parameter logic [W-1:0]  PULL_MASK = {2'b00, {(W-2){1'b1}}}
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] dout_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] pull_o
);

    for (genvar n = 0; n < int'(W); n++) begin : g_pin
        assign oe_o[n]  = dir_i[n];
        assign out_o[n] = dir_i[n] & dout_i[n];
        if (PULL_MASK[n]) begin : g_pull
            assign pull_o[n] = ~dir_i[n] & dout_i[n];
        end else begin : g_nopull
            assign pull_o[n] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned  W           = 8,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter logic [W-1:0] PULL_MASK   = {2'b00, {(W-2){1'b1}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pull_en,
    output logic              irq
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] esel;
        logic [W-1:0] flag;
        logic [W-1:0] ien;
    } port_st_t;

    port_st_t     st_d, st_q;
    logic [W-1:0] level, rise, fall, hit;
    logic [W-1:0] flag_q, esel_q;
    logic         wr_en;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .level_o(level),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_pad_ctrl #(.W(W), .PULL_MASK(PULL_MASK)) u_pad (
        .dir_i (st_q.dir),
        .dout_i(st_q.dout),
        .oe_o  (pad_oe),
        .out_o (pad_out),
        .pull_o(pad_pull_en)
    );

    assign wr_en = bus_sel & bus_wr;
    assign hit   = (rise & ~st_q.esel) | (fall & st_q.esel);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr_e'(bus_addr))
                RA_DIR:  st_d.dir  = bus_wdata;
                RA_DOUT: st_d.dout = bus_wdata;
                RA_EDGE: st_d.esel = bus_wdata;
                RA_FLAG: st_d.flag = bus_wdata;
                RA_IEN:  st_d.ien  = bus_wdata;
                default: ;
            endcase
        end
        // edge set is OR-ed after the bus load so it wins over a clear
        st_d.flag = st_d.flag | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (reg_addr_e'(bus_addr))
                RA_DIR:   bus_rdata = st_q.dir;
                RA_DOUT:  bus_rdata = st_q.dout;
                RA_LEVEL: bus_rdata = level;
                RA_EDGE:  bus_rdata = st_q.esel;
                RA_FLAG:  bus_rdata = st_q.flag;
                RA_IEN:   bus_rdata = st_q.ien;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq    = |(st_q.flag & st_q.ien);
    assign flag_q = st_q.flag;
    assign esel_q = st_q.esel;

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] PULL_MASK = {2'b00, {(W-2){1'b1}}}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pad_pull_en,
    input logic              irq,
    input logic [W-1:0]      flag_q,
    input logic [W-1:0]      esel_q,
    input logic [W-1:0]      rise,
    input logic [W-1:0]      fall
);

    logic flag_wr, ien_wr;
    assign flag_wr = bus_sel && bus_wr && (bus_addr == RA_FLAG);
    assign ien_wr  = bus_sel && bus_wr && (bus_addr == RA_IEN);

    a_r3_pull_only_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    a_r4_no_pull_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & ~PULL_MASK) == '0);

    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_wr && !ien_wr) |=> irq);

    for (genvar n = 0; n < int'(W); n++) begin : g_bit
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[n] && !flag_wr) |=> flag_q[n]);

        a_r8_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && bus_wdata[n]) |=> flag_q[n]);

        a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ((rise[n] && !esel_q[n]) || (fall[n] && esel_q[n])) |=> flag_q[n]);
    end

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .PULL_MASK(PULL_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_oe     (pad_oe),
    .pad_pull_en(pad_pull_en),
    .irq        (irq),
    .flag_q     (flag_q),
    .esel_q     (esel_q),
    .rise       (rise),
    .fall       (fall)
);

// File: tb/gpio_edge_port_tb.sv
`timescale 1ns/1ps
module gpio_edge_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, pin_in;
    logic [7:0] pad_oe, pad_out, pad_pull_en;
    logic       irq;

    always #4 clk = ~clk;

    gpio_edge_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_en(pad_pull_en), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // requirement-level model state
    logic [7:0] m_dir, m_dout, m_esel, m_flag, m_ien;
    logic [7:0] m_s1, m_s2, m_prev;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(int a);
        case (a)
            0: return m_dir;
            1: return m_dout;
            2: return m_s2;
            3: return m_esel;
            4: return m_flag;
            5: return m_ien;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rtag(int a);
        case (a)
            0: return "R1 direction readback";
            1: return "R2 output data readback";
            2: return "R5 level readback";
            3: return "R6 edge select readback";
            4: return "R7 flag readback";
            5: return "R9 enable readback";
            default: return "R12 unused address";
        endcase
    endfunction

    task automatic rd_chk(string req, int a, logic [7:0] exp);
        bus_addr = a[2:0];
        #0.1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic check_all();
        chk("R1 pad_oe", pad_oe, m_dir);
        chk("R2 pad_out", pad_out, m_dout & m_dir);
        chk("R3 pad_pull_en", pad_pull_en, ~m_dir & m_dout & 8'h3F);
        chk("R9 irq", {7'b0, irq}, {7'b0, |(m_flag & m_ien)});
        for (int a = 0; a < 8; a++) rd_chk(rtag(a), a, exp_read(a));
    endtask

    task automatic step(logic wr, int a, logic [7:0] d, logic [7:0] pins);
        logic [7:0] hit, nflag;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a[2:0];
        bus_wdata = d; pin_in = pins;
        hit   = (~m_esel & m_s2 & ~m_prev) | (m_esel & ~m_s2 & m_prev);
        nflag = m_flag;
        if (wr) begin
            case (a)
                0: m_dir  = d;
                1: m_dout = d;
                3: m_esel = d;
                4: nflag  = d;
                5: m_ien  = d;
                default: ;
            endcase
        end
        m_flag = nflag | hit;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pins;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = 8'hFF;
        {m_dir, m_dout, m_esel, m_flag, m_ien} = '0;
        {m_s1, m_s2, m_prev} = '0;
        repeat (3) @(posedge clk);
        #1;
        bus_sel = 1'b1;
        // R11: reset state
        chk("R11 reset pad_oe", pad_oe, 8'h00);
        chk("R11 reset pad_out", pad_out, 8'h00);
        chk("R11 reset pull", pad_pull_en, 8'h00);
        chk("R11 reset irq", {7'b0, irq}, 8'h00);
        for (int a = 0; a < 8; a++) rd_chk("R11 reset register", a, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        rd_chk("R11 pin high through reset sets no flag", 4, 8'h00);
        m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF;
        rd_chk("R5 level after reset", 2, 8'hFF);

        // R3 / R4: pull-ups as inputs with output data all ones
        step(1, 1, 8'hFF, 8'hFF);
        chk("R4 top pins no pull", pad_pull_en & 8'hC0, 8'h00);
        chk("R3 pull on low pins", pad_pull_en, 8'h3F);
        step(1, 0, 8'h0F, 8'hFF);
        chk("R2 drive only outputs", pad_out, 8'h0F);
        // R8: software set then clear
        step(1, 4, 8'hA5, 8'hFF);
        rd_chk("R8 software set", 4, 8'hA5);
        step(1, 4, 8'h00, 8'hFF);
        // R6: mixed polarity
        step(1, 3, 8'h0F, 8'hFF);
        step(0, 0, 8'h00, 8'h00);
        step(0, 0, 8'h00, 8'h00);
        rd_chk("R6 not yet set one edge early", 4, 8'h00);
        step(0, 0, 8'h00, 8'h00);
        rd_chk("R6 falling on low nibble only", 4, 8'h0F);
        step(0, 0, 8'h00, 8'hFF);
        step(0, 0, 8'h00, 8'hFF);
        step(0, 0, 8'h00, 8'hFF);
        rd_chk("R6 rising on high nibble", 4, 8'hFF);
        // R9: enable gating
        step(1, 5, 8'h01, 8'hFF);
        chk("R9 irq enabled flag", {7'b0, irq}, 8'h01);
        step(1, 4, 8'h00, 8'hFF);
        chk("R9 irq after clear", {7'b0, irq}, 8'h00);
        // R10: edge and clear on the same edge
        step(1, 3, 8'h00, 8'h00);
        step(0, 0, 8'h00, 8'h00);
        step(0, 0, 8'h00, 8'h00);
        step(1, 4, 8'h00, 8'h00);
        step(0, 0, 8'h00, 8'h01);
        step(0, 0, 8'h00, 8'h01);
        step(1, 4, 8'h00, 8'h01);
        rd_chk("R10 edge beats clear", 4, 8'h01);
        // R12: unused addresses
        step(1, 6, 8'hFF, 8'h01);
        step(1, 7, 8'hFF, 8'h01);
        step(1, 2, 8'hFF, 8'h01);

        // random phase
        pins = 8'h01;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) pins = pins ^ 8'($urandom & $urandom);
            step(r[3:1] < 3'd3, int'(r[6:4]), 8'($urandom), pins);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule